// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Unit

This unit holds a small bank of single-bit tokens that two independent ports, left and right, use to tell their software which side currently has a privilege over a shared resource. A port asks for a token by writing a 0 to it and gives it back by writing a 1. A token that nobody holds is free. A read shows 0 only to the side that holds the token, and 1 to everyone else. The tokens are advisory. Nothing here blocks the shared memory. Each side's software decides what holding a token means.

Every token has its own three-state controller: `FREE`, `HELD_LEFT` and `HELD_RIGHT`. Each port's wish to hold a token is kept in a per-token request bit. The request is set by a 0-write and cleared by a 1-write. Ownership follows from these request bits:

- `claim_left`: `FREE` to `HELD_LEFT`, when the left request is set. This also wins when both sides ask in the same cycle.
- `claim_right`: `FREE` to `HELD_RIGHT`, when only the right request is set.
- `release_left`: `HELD_LEFT` to `FREE`, when the left request clears and no right request is pending.
- `release_right`: `HELD_RIGHT` to `FREE`, the mirror case.
- `handover_to_right`: `HELD_LEFT` to `HELD_RIGHT`, when the left request clears while a right request is pending.
- `handover_to_left`: `HELD_RIGHT` to `HELD_LEFT`, the mirror case.

All other cases hold the current state. A write takes effect at the next rising clock edge. Reads are combinational from the registered state.

Each port also has a memory enable that is separate from its semaphore enable. When both are deasserted (high), the port raises a standby indication.

Top module: `sem_flag_unit`

## Requirements
- R1: After reset all eight tokens are `FREE`, and every address reads 1 on both ports.
- R2: A port writes data 0 to a free token, with its semaphore enable low (active) and its write strobe low. From the next cycle, that port reads 0 at that address and the other port reads 1.
- R3: A token is never held by both ports at once. A 0-write to a token held by the other side leaves the holder unchanged.
- R4: A 1-write by the holder releases the token at the next edge. If the other side has a pending request, the token passes straight to that side; otherwise it becomes free.
- R5: A 1-write by a side whose request is still pending withdraws the request. A later release by the holder then leaves the token free.
- R6: If both ports write 0 to the same free token in the same cycle, the left port obtains it and the right request stays pending.
- R7: A write changes only the token at its 3-bit address (0 to 7). All other tokens keep their state.
- R8: Writes made while the semaphore enable is high are ignored, whatever the memory enable does.
- R9: A port's standby output is 1 exactly when both its memory enable and its semaphore enable are high.
- R10: While a port's semaphore enable is high, its read data is 1, even for a token that the port holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_mem_en_n | input | 1 | Left memory enable, active low (standby decode only) |
| l_sem_en_n | input | 1 | Left semaphore enable, active low |
| l_addr | input | 3 | Left token address |
| l_wr_n | input | 1 | Left write strobe, active low |
| l_wdata | input | 1 | Left write data: 0 requests, 1 releases |
| l_rdata | output | 1 | Left read data: 0 when left holds the token |
| l_standby | output | 1 | Left standby indication |
| r_mem_en_n | input | 1 | Right memory enable, active low (standby decode only) |
| r_sem_en_n | input | 1 | Right semaphore enable, active low |
| r_addr | input | 3 | Right token address |
| r_wr_n | input | 1 | Right write strobe, active low |
| r_wdata | input | 1 | Right write data: 0 requests, 1 releases |
| r_rdata | output | 1 | Right read data: 0 when right holds the token |
| r_standby | output | 1 | Right standby indication |

## Verification
Two events can fall in the same cycle, and both must resolve in one edge:

- One side writes to a token while the other side writes to it too: a request, a release, or both.
- A release by the holder meets a pending request from the opposite side.

A sweep drives every pair of left and right addresses with every combination of request and release data in the same cycle. After each step it reads all eight tokens from both ports. Each result is judged against a request-and-owner model that the bench keeps from the rules above. Directed sequences then set up the specific cases: tie, withdrawal and hand-over.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [1:0] {
        FREE       = 2'd0,
        HELD_LEFT  = 2'd1,
        HELD_RIGHT = 2'd2
    } flag_state_t;

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = $clog2(NUM_FLAGS)
) (
    input  logic                 mem_en_n,
    input  logic                 sem_en_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_n,
    input  logic                 wdata,
    output logic [NUM_FLAGS-1:0] set_vec,
    output logic [NUM_FLAGS-1:0] clr_vec,
    output logic                 standby
);

    logic wr_active;

    assign wr_active = !sem_en_n && !wr_n;
    assign standby   = mem_en_n && sem_en_n;

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_dec
        logic hit;
        assign hit        = wr_active && (addr == ADDR_W'(k));
        assign set_vec[k] = hit && !wdata;
        assign clr_vec[k] = hit && wdata;
    end

endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_l,
    input  logic clr_l,
    input  logic set_r,
    input  logic clr_r,
    output logic own_l,
    output logic own_r
);

    flag_state_t state_q, state_d;
    logic        req_l_q, req_r_q;
    logic        req_l_d, req_r_d;

    // request bits: a 0-write sets, a 1-write clears
    always_comb begin
        req_l_d = set_l ? 1'b1 : (clr_l ? 1'b0 : req_l_q);
        req_r_d = set_r ? 1'b1 : (clr_r ? 1'b0 : req_r_q);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FREE;
            req_l_q <= 1'b0;
            req_r_q <= 1'b0;
        end else begin
            state_q <= state_d;
            req_l_q <= req_l_d;
            req_r_q <= req_r_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FREE: begin
                if (req_l_d)      state_d = HELD_LEFT;   // claim_left (wins ties)
                else if (req_r_d) state_d = HELD_RIGHT;  // claim_right
            end
            HELD_LEFT: begin
                if (!req_l_d)     state_d = req_r_d ? HELD_RIGHT : FREE;
            end
            HELD_RIGHT: begin
                if (!req_r_d)     state_d = req_l_d ? HELD_LEFT : FREE;
            end
            default:              state_d = FREE;
        endcase
    end

    // outputs
    always_comb begin
        own_l = 1'b0;
        own_r = 1'b0;
        unique case (state_q)
            FREE:       ;
            HELD_LEFT:  own_l = 1'b1;
            HELD_RIGHT: own_r = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/sem_read_mux.sv
module sem_read_mux #(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = $clog2(NUM_FLAGS)
) (
    input  logic                 sem_en_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_FLAGS-1:0] own_vec,
    output logic                 rdata
);

    always_comb begin
        rdata = 1'b1;
        if (!sem_en_n) rdata = !own_vec[addr];
    end

endmodule

// File: rtl/sem_flag_unit.sv
module sem_flag_unit #(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = $clog2(NUM_FLAGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_mem_en_n,
    input  logic              l_sem_en_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_wr_n,
    input  logic              l_wdata,
    output logic              l_rdata,
    output logic              l_standby,
    input  logic              r_mem_en_n,
    input  logic              r_sem_en_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_wr_n,
    input  logic              r_wdata,
    output logic              r_rdata,
    output logic              r_standby
);

    logic [NUM_FLAGS-1:0] set_l, clr_l, set_r, clr_r;
    logic [NUM_FLAGS-1:0] own_l, own_r;

    sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) dec_l_i (
        .mem_en_n (l_mem_en_n),
        .sem_en_n (l_sem_en_n),
        .addr     (l_addr),
        .wr_n     (l_wr_n),
        .wdata    (l_wdata),
        .set_vec  (set_l),
        .clr_vec  (clr_l),
        .standby  (l_standby)
    );

    sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) dec_r_i (
        .mem_en_n (r_mem_en_n),
        .sem_en_n (r_sem_en_n),
        .addr     (r_addr),
        .wr_n     (r_wr_n),
        .wdata    (r_wdata),
        .set_vec  (set_r),
        .clr_vec  (clr_r),
        .standby  (r_standby)
    );

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
        sem_flag_cell cell_i (
            .clk   (clk),
            .rst_n (rst_n),
            .set_l (set_l[k]),
            .clr_l (clr_l[k]),
            .set_r (set_r[k]),
            .clr_r (clr_r[k]),
            .own_l (own_l[k]),
            .own_r (own_r[k])
        );
    end

    sem_read_mux #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) rd_l_i (
        .sem_en_n (l_sem_en_n),
        .addr     (l_addr),
        .own_vec  (own_l),
        .rdata    (l_rdata)
    );

    sem_read_mux #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) rd_r_i (
        .sem_en_n (r_sem_en_n),
        .addr     (r_addr),
        .own_vec  (own_r),
        .rdata    (r_rdata)
    );

endmodule

// File: rtl/sem_flag_checker.sv
module sem_flag_checker #(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = $clog2(NUM_FLAGS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 l_sem_en_n,
    input logic [ADDR_W-1:0]    l_addr,
    input logic                 l_wr_n,
    input logic                 l_wdata,
    input logic                 l_rdata,
    input logic                 r_sem_en_n,
    input logic [ADDR_W-1:0]    r_addr,
    input logic                 r_wr_n,
    input logic                 r_wdata,
    input logic                 r_rdata,
    input logic [NUM_FLAGS-1:0] own_l,
    input logic [NUM_FLAGS-1:0] own_r
);

    logic l_wr, r_wr;
    assign l_wr = !l_sem_en_n && !l_wr_n;
    assign r_wr = !r_sem_en_n && !r_wr_n;

    p_mutex_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (own_l & own_r) == '0);

    p_claim_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (l_wr && !l_wdata && !own_l[l_addr] && !own_r[l_addr])
        |=> own_l[$past(l_addr)]);

    p_tie_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (l_wr && r_wr && !l_wdata && !r_wdata && (l_addr == r_addr)
         && !own_l[l_addr] && !own_r[l_addr])
        |=> own_l[$past(l_addr)] && !own_r[$past(l_addr)]);

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (l_wr && l_wdata) |=> !own_l[$past(l_addr)]);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_wr && !r_wdata && own_l[r_addr] && !(l_wr && l_wdata && (l_addr == r_addr)))
        |=> own_l[$past(r_addr)]);

    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_wr && !r_wr) |=> ($stable(own_l) && $stable(own_r)));

    p_idle_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sem_en_n |-> l_rdata) and (r_sem_en_n |-> r_rdata));

endmodule

bind sem_flag_unit sem_flag_checker #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/sem_flag_unit_tb.sv
module sem_flag_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NF         = 8;
    localparam int AW         = 3;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n;
    logic l_mem_en_n, l_sem_en_n, l_wr_n, l_wdata, l_rdata, l_standby;
    logic r_mem_en_n, r_sem_en_n, r_wr_n, r_wdata, r_rdata, r_standby;
    logic [AW-1:0] l_addr, r_addr;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    // model: 0 free, 1 left, 2 right
    int m_own [NF];
    bit m_rl  [NF];
    bit m_rr  [NF];

    always #(CLK_PERIOD/2) clk = ~clk;

    sem_flag_unit #(.NUM_FLAGS(NF), .ADDR_W(AW)) dut_i (.*);

    task automatic chk(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < NF; k++) begin
            m_own[k] = 0; m_rl[k] = 0; m_rr[k] = 0;
        end
    endtask

    task automatic model_step(bit lw, int la, bit lv, bit rw, int ra, bit rv);
        if (lw) m_rl[la] = !lv;
        if (rw) m_rr[ra] = !rv;
        for (int k = 0; k < NF; k++) begin
            if (m_own[k] == 0)                m_own[k] = m_rl[k] ? 1 : (m_rr[k] ? 2 : 0);
            else if (m_own[k] == 1 && !m_rl[k]) m_own[k] = m_rr[k] ? 2 : 0;
            else if (m_own[k] == 2 && !m_rr[k]) m_own[k] = m_rl[k] ? 1 : 0;
        end
    endtask

    task automatic idle();
        l_mem_en_n = 1; l_sem_en_n = 1; l_wr_n = 1; l_wdata = 1; l_addr = '0;
        r_mem_en_n = 1; r_sem_en_n = 1; r_wr_n = 1; r_wdata = 1; r_addr = '0;
    endtask

    // one cycle of (possibly simultaneous) semaphore writes
    task automatic wr(bit lw, int la, bit lv, bit rw, int ra, bit rv);
        @(negedge clk);
        idle();
        l_sem_en_n = !lw; l_wr_n = !lw; l_addr = AW'(la); l_wdata = lv;
        r_sem_en_n = !rw; r_wr_n = !rw; r_addr = AW'(ra); r_wdata = rv;
        @(posedge clk);
        model_step(lw, la, lv, rw, ra, rv);
    endtask

    // read all tokens from both ports and compare (R7 independence)
    task automatic verify_all(string tag);
        for (int k = 0; k < NF; k++) begin
            @(negedge clk);
            idle();
            l_sem_en_n = 0; l_addr = AW'(k);
            r_sem_en_n = 0; r_addr = AW'(k);
            #1;
            chk({tag, " left"},  l_rdata, (m_own[k] == 1) ? 1'b0 : 1'b1);
            chk({tag, " right"}, r_rdata, (m_own[k] == 2) ? 1'b0 : 1'b1);
        end
        @(negedge clk);
        idle();
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        idle();
        rst_n = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        verify_all("R1 reset all free");

        // R2: left claims 2, right claims 5
        wr(1, 2, 0, 1, 5, 0);
        verify_all("R2 claim");

        // R3: right asks for 2 held by left: stays left, request pends
        wr(0, 0, 1, 1, 2, 0);
        verify_all("R3 contention holder kept");

        // R4: left releases 2 -> hand-over to right
        wr(1, 2, 1, 0, 0, 1);
        verify_all("R4 handover");
        // R4: right releases 2 -> free
        wr(0, 0, 1, 1, 2, 1);
        verify_all("R4 release to free");

        // R6: tie on free token 6
        wr(1, 6, 0, 1, 6, 0);
        verify_all("R6 tie left wins");
        wr(1, 6, 1, 0, 0, 1);
        verify_all("R6 pending right gets token");
        wr(0, 0, 1, 1, 6, 1);

        // R5: left holds 4, right pends then withdraws, left releases -> free
        wr(1, 4, 0, 0, 0, 1);
        wr(0, 0, 1, 1, 4, 0);
        wr(0, 0, 1, 1, 4, 1);
        wr(1, 4, 1, 0, 0, 1);
        verify_all("R5 withdraw then release");

        // R8: writes with semaphore enable high are ignored
        @(negedge clk);
        idle();
        l_mem_en_n = 0; l_wr_n = 0; l_wdata = 0; l_addr = 3'd1;
        r_mem_en_n = 0; r_wr_n = 0; r_wdata = 0; r_addr = 3'd7;
        @(posedge clk);
        verify_all("R8 disabled write ignored");

        // R10: owner reads 1 while semaphore enable high
        wr(1, 3, 0, 0, 0, 1);
        @(negedge clk);
        idle();
        l_addr = 3'd3; r_addr = 3'd3;
        #1;
        chk("R10 left idle read", l_rdata, 1'b1);
        chk("R10 right idle read", r_rdata, 1'b1);
        l_sem_en_n = 0;
        #1;
        chk("R10 left enabled owner read", l_rdata, 1'b0);

        // R9: standby decode, all four combinations, within one low phase
        @(negedge clk);
        idle();
        for (int c = 0; c < 4; c++) begin
            l_wr_n = 1; r_wr_n = 1;
            l_mem_en_n = c[0]; l_sem_en_n = c[1];
            r_mem_en_n = c[1]; r_sem_en_n = c[0];
            #1;
            chk("R9 left standby",  l_standby, (c == 3) ? 1'b1 : 1'b0);
            chk("R9 right standby", r_standby, (c == 3) ? 1'b1 : 1'b0);
        end
        @(negedge clk);
        idle();

        // sweep: every address pair, every data pair, simultaneous writes
        for (int a = 0; a < NF; a++) begin
            for (int b = 0; b < NF; b++) begin
                for (int d = 0; d < 4; d++) begin
                    wr(1, a, d[0], 1, b, d[1]);
                    verify_all("R3 R4 R6 R7 sweep");
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule